// File: doc/BRIEF.md
# Partitioned Pixel Pack Unit

This datapath block turns partitioned fixed-point data into packed pixel bytes and back. Each accepted request carries a 9-bit operation code, two 64-bit source operands and the 5-bit scale field of the graphics status register (register bits [7:3]). One clock later the block returns a 64-bit result and an illegal-operation flag. Three operations pack: signed 16-bit lanes to unsigned bytes, signed 32-bit words to unsigned bytes shifted into earlier contents, and signed 32-bit words to saturated signed 16-bit values. Two operations rearrange bytes: an expand that widens bytes into 16-bit fixed-point lanes, and a merge that interleaves two 32-bit operands.

Each pack operation shifts its lanes left by the scale, then arithmetically right by a fraction width of its own, and clamps to its own range. The intermediate values are 64 bits wide, so even the largest scale loses neither sign nor magnitude before the clamp. The sequencing is a two-state machine. `ST_IDLE` means no fresh result is held. `ST_RESULT` means the output registers hold the result of the previous cycle's request. The transition `accept` (in_valid high) enters or stays in `ST_RESULT` from either state. The transition `drain` (in_valid low) returns to `ST_IDLE` from either state.

Top module: `pixel_pack_unit`

## Requirements
- R1: While rst_n is low, and at the first sample after reset, out_valid, illegal and result are all zero.
- R2: A cycle with in_valid high gives out_valid high exactly one clock later, with result and illegal for that request. A cycle with in_valid low gives out_valid low one clock later, and result and illegal keep their previous values even when the other inputs change.
- R3: Operation 0x03B (lane pack) takes each signed 16-bit lane k of src_b, shifts it left by stat_scale[3:0] and arithmetically right by 7, and clamps the value to 0..255. It writes the value to result byte k. Result bits [63:32] are zero.
- R4: The lane pack ignores stat_scale[4] (status bit 7). Its scale is four bits only.
- R5: Operation 0x03A (word pack) starts from src_a shifted left by 8, with result bytes 0 and 4 cleared. Each signed 32-bit word k of src_b is shifted left by the full 5-bit scale and arithmetically right by 23, then clamped to 0..255. That value fills byte 0 of 32-bit half k.
- R6: Operation 0x03D (fixed pack) takes each signed 32-bit word k of src_b, shifts it left by the 5-bit scale and arithmetically right by 16, and saturates it to -32768..32767. It writes the value to result bits [16k+15:16k]. Result bits [63:32] are zero.
- R7: Operation 0x04D (expand) places byte k of src_b[31:0], zero-extended and shifted left by 4, in result bits [16k+15:16k]. src_b[63:32] has no effect.
- R8: Operation 0x04B (merge) writes byte k of src_b to result byte 2k and byte k of src_a to result byte 2k+1, for k = 0..3. The upper halves of the operands have no effect.
- R9: Any other operation code sets illegal and gives an all-zero result. The five codes above clear illegal.
- R10: With a scale of 31, the word pack and the fixed pack still clamp by the true sign and magnitude of the shifted value. No wrap-around occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for the current inputs |
| op_code | input | 9 | Operation code |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| stat_scale | input | 5 | Scale field, status register bits [7:3] |
| out_valid | output | 1 | Result registers hold a fresh result |
| result | output | 64 | Registered result |
| illegal | output | 1 | Registered flag for an unrecognised operation code |

## Verification
The timing properties assume that in_valid is a clean, two-valued level that is sampled only on rising edges. The bench drives every input only on falling edges, so each request is seen at exactly one rising edge. The per-operation properties compare result bits with the operands of the previous cycle. For that reason they assume nothing changes operands between the accepting edge and the next one other than the bench's own falling-edge drive, and that holds by construction in the bench. Reset is asserted only on a falling edge and is held for several cycles, so no property is evaluated against values from before reset.

// File: rtl/ppk_pkg.sv
package ppk_pkg;
    localparam int OPC_W    = 9;
    localparam int DATA_W   = 64;
    localparam int WIDE_W   = 64;
    localparam int SCALE_W  = 5;
    localparam int BYTE_W   = 8;

    localparam logic [OPC_W-1:0] OPC_PACK16 = 9'h03B;
    localparam logic [OPC_W-1:0] OPC_PACK32 = 9'h03A;
    localparam logic [OPC_W-1:0] OPC_FIX    = 9'h03D;
    localparam logic [OPC_W-1:0] OPC_EXPAND = 9'h04D;
    localparam logic [OPC_W-1:0] OPC_MERGE  = 9'h04B;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } ppk_state_e;

    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_PACK16 = 3'd1,
        SEL_PACK32 = 3'd2,
        SEL_FIX    = 3'd3,
        SEL_EXPAND = 3'd4,
        SEL_MERGE  = 3'd5
    } ppk_sel_e;

    // Unsigned byte clamp of a wide signed intermediate
    function automatic logic [BYTE_W-1:0] clamp_u8(input logic signed [WIDE_W-1:0] v);
        if (v < 0)
            return '0;
        else if (v > 255)
            return 8'hFF;
        else
            return v[BYTE_W-1:0];
    endfunction

    // Signed 16-bit saturation of a wide signed intermediate
    function automatic logic [15:0] sat_s16(input logic signed [WIDE_W-1:0] v);
        if (v < -64'sd32768)
            return 16'h8000;
        else if (v > 64'sd32767)
            return 16'h7FFF;
        else
            return v[15:0];
    endfunction
endpackage

// File: rtl/ppk_pack16.sv
module ppk_pack16
    import ppk_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int LANE_W  = 16,
    parameter int FRAC_SH = 7,
    parameter int SCL_W   = 4
) (
    input  logic [LANES*LANE_W-1:0] lanes_i,
    input  logic [SCL_W-1:0]        scale_i,
    output logic [LANES*BYTE_W-1:0] pix_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [WIDE_W-1:0] widened;
        logic signed [WIDE_W-1:0] scaled;
        assign widened = WIDE_W'(signed'(lanes_i[k*LANE_W +: LANE_W]));
        assign scaled  = (widened <<< scale_i) >>> FRAC_SH;
        assign pix_o[k*BYTE_W +: BYTE_W] = clamp_u8(scaled);
    end
endmodule

// File: rtl/ppk_pack32.sv
module ppk_pack32
    import ppk_pkg::*;
#(
    parameter int WORDS     = 2,
    parameter int WORD_W    = 32,
    parameter int FRAC_BYTE = 23,
    parameter int FRAC_FIX  = 16,
    parameter int FIX_W     = 16
) (
    input  logic [WORDS*WORD_W-1:0] prev_i,
    input  logic [WORDS*WORD_W-1:0] words_i,
    input  logic [SCALE_W-1:0]      scale_i,
    output logic [WORDS*WORD_W-1:0] byte_pack_o,
    output logic [WORDS*FIX_W-1:0]  fix_pack_o
);
    localparam int TOT_W = WORDS * WORD_W;
    // Keep everything except the low byte of each word
    localparam logic [TOT_W-1:0] KEEP_MASK =
        {WORDS{ {(WORD_W-BYTE_W){1'b1}}, {BYTE_W{1'b0}} }};

    logic [TOT_W-1:0] shifted_prev;
    logic [TOT_W-1:0] inserts;

    assign shifted_prev = (prev_i << BYTE_W) & KEEP_MASK;

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        logic signed [WIDE_W-1:0] widened;
        logic signed [WIDE_W-1:0] up;
        assign widened = WIDE_W'(signed'(words_i[k*WORD_W +: WORD_W]));
        assign up      = widened <<< scale_i;
        assign inserts[k*WORD_W +: WORD_W] =
            {{(WORD_W-BYTE_W){1'b0}}, clamp_u8(up >>> FRAC_BYTE)};
        assign fix_pack_o[k*FIX_W +: FIX_W] = sat_s16(up >>> FRAC_FIX);
    end

    assign byte_pack_o = shifted_prev | inserts;
endmodule

// File: rtl/ppk_rearrange.sv
module ppk_rearrange
    import ppk_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int EXP_SH = 4,
    parameter int LANE_W = 16
) (
    input  logic [NBYTES*BYTE_W-1:0]   a_lo_i,
    input  logic [NBYTES*BYTE_W-1:0]   b_lo_i,
    output logic [NBYTES*LANE_W-1:0]   expand_o,
    output logic [2*NBYTES*BYTE_W-1:0] merge_o
);
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign expand_o[k*LANE_W +: LANE_W] =
            LANE_W'({b_lo_i[k*BYTE_W +: BYTE_W], {EXP_SH{1'b0}}});
        assign merge_o[(2*k)*BYTE_W   +: BYTE_W] = b_lo_i[k*BYTE_W +: BYTE_W];
        assign merge_o[(2*k+1)*BYTE_W +: BYTE_W] = a_lo_i[k*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/pixel_pack_unit.sv
module pixel_pack_unit
    import ppk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [SCALE_W-1:0] stat_scale,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);
    localparam int HALF_W = DATA_W / 2;

    ppk_state_e state_q, state_d;
    ppk_sel_e   sel;

    logic [HALF_W-1:0] pk16_res;
    logic [DATA_W-1:0] pk32_res;
    logic [HALF_W-1:0] fix_res;
    logic [DATA_W-1:0] exp_res;
    logic [DATA_W-1:0] mrg_res;
    logic [DATA_W-1:0] res_d;

    ppk_pack16 #(.LANES(4), .LANE_W(16), .FRAC_SH(7), .SCL_W(SCALE_W-1)) u_pack16 (
        .lanes_i (src_b),
        .scale_i (stat_scale[SCALE_W-2:0]),
        .pix_o   (pk16_res)
    );

    ppk_pack32 #(.WORDS(2), .WORD_W(32), .FRAC_BYTE(23), .FRAC_FIX(16), .FIX_W(16)) u_pack32 (
        .prev_i      (src_a),
        .words_i     (src_b),
        .scale_i     (stat_scale),
        .byte_pack_o (pk32_res),
        .fix_pack_o  (fix_res)
    );

    ppk_rearrange #(.NBYTES(4), .EXP_SH(4), .LANE_W(16)) u_rearr (
        .a_lo_i   (src_a[HALF_W-1:0]),
        .b_lo_i   (src_b[HALF_W-1:0]),
        .expand_o (exp_res),
        .merge_o  (mrg_res)
    );

    // Operation decode
    always_comb begin
        unique case (op_code)
            OPC_PACK16: sel = SEL_PACK16;
            OPC_PACK32: sel = SEL_PACK32;
            OPC_FIX:    sel = SEL_FIX;
            OPC_EXPAND: sel = SEL_EXPAND;
            OPC_MERGE:  sel = SEL_MERGE;
            default:    sel = SEL_NONE;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_PACK16: res_d = {{HALF_W{1'b0}}, pk16_res};
            SEL_PACK32: res_d = pk32_res;
            SEL_FIX:    res_d = {{HALF_W{1'b0}}, fix_res};
            SEL_EXPAND: res_d = exp_res;
            SEL_MERGE:  res_d = mrg_res;
            default:    res_d = '0;
        endcase
    end

    // Next state: accept / drain
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result  <= '0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            result  <= res_d;
            illegal <= (sel == SEL_NONE);
        end
    end

    assign out_valid = (state_q == ST_RESULT);

    // Timing
    assert_valid_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(illegal)));

    // Illegal code gives zero
    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (result == '0));

    // Lane pack leaves the upper half clear
    assert_pack16_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OPC_PACK16) |=> (result[DATA_W-1:HALF_W] == '0 && !illegal));

    // Fixed pack leaves the upper half clear
    assert_fix_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OPC_FIX) |=> (result[DATA_W-1:HALF_W] == '0 && !illegal));

    // Word pack carries shifted previous bytes
    assert_pack32_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OPC_PACK32) |=> (result[31:8] == $past(src_a[23:0])));

    // Merge odd byte from first operand
    assert_merge_odd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OPC_MERGE) |=>
            (result[15:8] == $past(src_a[7:0]) && result[7:0] == $past(src_b[7:0])));
endmodule

// File: tb/tb_pixel_pack_unit.sv
`timescale 1ns/1ps
module tb_pixel_pack_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [8:0]  op_code = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [4:0]  stat_scale = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pixel_pack_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .stat_scale(stat_scale),
        .out_valid(out_valid), .result(result), .illegal(illegal)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic [8:0]  op;
        logic [4:0]  sc;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
        logic        ill;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{"R3",  9'h03B, 5'd0,  64'h0, 64'h0080_8000_7FFF_0100, 64'h0000_0000_0100_FF02, 1'b0},
        '{"R3",  9'h03B, 5'd4,  64'h0, 64'hFFFF_00FF_0008_0010, 64'h0000_0000_001F_0102, 1'b0},
        '{"R4",  9'h03B, 5'h11, 64'h0, 64'h0000_0000_0000_0040, 64'h0000_0000_0000_0001, 1'b0},
        '{"R5",  9'h03A, 5'd0,  64'h1122_3344_5566_7788, 64'h7FFF_FFFF_0080_0000, 64'h2233_44FF_6677_8801, 1'b0},
        '{"R5",  9'h03A, 5'd8,  64'h0, 64'hFFFF_FFFF_0001_0000, 64'h0000_0000_0000_0002, 1'b0},
        '{"R10", 9'h03A, 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_0000_0001, 64'hFFFF_FF00_FFFF_FFFF, 1'b0},
        '{"R6",  9'h03D, 5'd0,  64'h0, 64'hFFFF_0000_0001_0000, 64'h0000_0000_FFFF_0001, 1'b0},
        '{"R6",  9'h03D, 5'd16, 64'h0, 64'hFFFF_8000_0000_8000, 64'h0000_0000_8000_7FFF, 1'b0},
        '{"R10", 9'h03D, 5'd31, 64'h0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_7FFF, 1'b0},
        '{"R7",  9'h04D, 5'h1F, 64'h1234_5678_9ABC_DEF0, 64'hDEAD_BEEF_FF80_0102, 64'h0FF0_0800_0010_0020, 1'b0},
        '{"R8",  9'h04B, 5'h0A, 64'h5555_5555_A3A2_A1A0, 64'h6666_6666_B3B2_B1B0, 64'hA3B3_A2B2_A1B1_A0B0, 1'b0},
        '{"R9",  9'h03C, 5'd0,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1},
        '{"R9",  9'h1FF, 5'd3,  64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0, 1'b1}
    };

    task automatic check(input string req, input logic [65:0] act, input logic [65:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual valid/illegal/result=%b/%b/%h expected %b/%b/%h",
                     req, act[65], act[64], act[63:0], exp[65], exp[64], exp[63:0]);
        end
    endtask

    task automatic drive(input vec_t v);
        in_valid = 1'b1; op_code = v.op; stat_scale = v.sc; src_a = v.a; src_b = v.b;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", {out_valid, illegal, result}, 66'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, illegal, result}, 66'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check(string'(VECS[i].tag), {out_valid, VECS[i].ill ? 1'b1 : illegal, result},
                  {1'b1, VECS[i].ill, VECS[i].exp});
            if (VECS[i].ill)
                check("R9", {1'b0, illegal, 64'h0}, {1'b0, 1'b1, 64'h0});
            @(negedge clk);
        end

        // R2: hold with changing inputs while idle
        drive(VECS[10]);
        @(negedge clk);
        in_valid = 1'b0; op_code = 9'h03C; src_a = '1; src_b = '1; stat_scale = 5'd7;
        check("R8", {out_valid, illegal, result}, {2'b10, VECS[10].exp});
        @(negedge clk);
        check("R2", {out_valid, illegal, result}, {2'b00, VECS[10].exp});
        @(negedge clk);
        check("R2", {out_valid, illegal, result}, {2'b00, VECS[10].exp});

        // R2: back-to-back requests, illegal then legal
        drive(VECS[11]);
        @(negedge clk);
        drive(VECS[3]);
        check("R2", {out_valid, illegal, result}, {2'b11, 64'h0});
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", {out_valid, illegal, result}, {2'b10, VECS[3].exp});
        @(negedge clk);

        // R1: reset after activity
        drive(VECS[9]);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", {out_valid, illegal, result}, 66'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, illegal, result}, 66'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule